// File: doc/BRIEF.md
# Serial Integrity-Chain Cell

This block is one clocked link of a distributed integrity chain. Cells are wired head to tail so that a serial message passes through every cell in turn. Each message has a reconfiguration section followed by a 64-bit payload. A cell takes the leading 5-bit field for itself as its routing configuration for the next session. It passes the remaining configuration fields on unchanged, so the message loses 5 bits at every hop. It then runs a keyed mixing step on the payload and sends the resulting digest downstream. The protected logic at the end of the chain recomputes the digest. A mismatch shows that a cell was bypassed or altered.

Each cell keeps a chained state word. The word starts at zero after reset and absorbs every complete payload, so a digest depends on all earlier sessions. A global commit strobe ends each session. On commit, every cell that captured a full field makes it active. A cell that did not capture a full field keeps its old routing and raises an error flag.

The sequencer steps through these states:

| State | What it does | Exit condition |
|---|---|---|
| CAP | Captures the cell's own field | After 5 valid bits, goes to FWD, or to PIN when no downstream fields exist |
| FWD | Forwards the downstream fields | After all of them, goes to PIN |
| PIN | Loads the payload | After 64 bits, goes to MAC |
| MAC | Applies the one-cycle mixing step | Always goes to EMIT |
| EMIT | Shifts the digest out | After 64 cycles, goes to DONE |
| DONE | Ignores input | Waits for commit |

A commit in any state returns the sequencer to CAP.

Top module: `canary_cell`

## Requirements
- R1: After reset or a commit, the first 5 valid input bits are captured as the next configuration, first bit as the most significant bit, and none of them appears at the output.
- R2: The next DOWN_CELLS*5 valid bits leave on out_bit, in order, each one clock cycle after it is accepted, with out_valid high.
- R3: The following 64 valid bits form the payload P. After one mixing cycle, the digest rotl(P ^ KEY ^ S, (A+1) mod 64) leaves most significant bit first, on 64 consecutive cycles with out_valid high. Here S is the chained state and A is the active configuration.
- R4: The chained state S is zero after reset. After each complete payload it becomes S ^ P ^ KEY, and it changes at no other time.
- R5: While reset is held, active_cfg equals DEFAULT_CFG, cfg_err is 0 and out_valid is 0.
- R6: A commit after a complete 5-bit capture loads the captured field into active_cfg on the next cycle and clears cfg_err.
- R7: A commit before 5 bits have been captured leaves active_cfg unchanged and sets cfg_err. cfg_err holds its value until the next commit.
- R8: active_cfg changes only in the cycle after a commit.
- R9: After the digest has been sent, further input bits are ignored until a commit: nothing is output and S is unchanged.
- R10: A commit in the middle of a message aborts it. A partly received payload does not change S, and capture restarts with the next bit.
- R11: Idle cycles, where in_valid is low, may fall between any two bits and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_bit carries a message bit this cycle |
| in_bit | input | 1 | Serial message input |
| commit | input | 1 | Session-boundary strobe |
| out_valid | output | 1 | out_bit carries a message bit this cycle |
| out_bit | output | 1 | Serial message output |
| active_cfg | output | 5 | Routing configuration of the current session |
| cfg_err | output | 1 | Last commit arrived before a full field was captured |

## Verification
The bench runs several sessions back to back. It checks that each digest reflects the state chained from every earlier payload. A cell that failed to update or failed to keep S would produce a wrong second or later digest. A cell that leaked its own field would output 84 bits instead of 79. It drives a short capture followed by a commit, where a faulty cell would load a partial field or miss the error flag. It drives a commit during the payload, where a faulty cell would fold the half-loaded payload into S. It sends bits after the digest, where a faulty cell would echo them or corrupt the state. Idle gaps inside a message catch any counter that advances without in_valid.

// File: rtl/canary_pkg.sv
package canary_pkg;
    typedef enum logic [2:0] {
        S_CAP,
        S_FWD,
        S_PIN,
        S_MAC,
        S_EMIT,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/canary_seq.sv
module canary_seq
    import canary_pkg::*;
#(
    parameter int CFG_W    = 5,
    parameter int FWD_BITS = 15,
    parameter int PAY_W    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_bit,
    input  logic       commit,
    input  logic       pay_msb,
    output seq_state_t st,
    output logic       cap_en,
    output logic       cap_full,
    output logic       pin_en,
    output logic       mac_go,
    output logic       emit_en,
    output logic       out_valid,
    output logic       out_bit
);
    localparam int MAXA   = (CFG_W > FWD_BITS) ? CFG_W : FWD_BITS;
    localparam int MAXLEN = (MAXA > PAY_W) ? MAXA : PAY_W;
    localparam int CNT_W  = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] LAST_CFG = CNT_W'(CFG_W - 1);
    localparam logic [CNT_W-1:0] LAST_FWD = CNT_W'((FWD_BITS > 0) ? FWD_BITS - 1 : 0);
    localparam logic [CNT_W-1:0] LAST_PAY = CNT_W'(PAY_W - 1);
    localparam seq_state_t AFTER_CAP = (FWD_BITS == 0) ? S_PIN : S_FWD;

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_inc, fwd_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_CAP;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (cnt_clr)      cnt <= '0;
            else if (cnt_inc) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt     = st;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        cap_en  = 1'b0;
        fwd_en  = 1'b0;
        pin_en  = 1'b0;
        mac_go  = 1'b0;
        emit_en = 1'b0;
        if (commit) begin
            nxt     = S_CAP;
            cnt_clr = 1'b1;
        end else begin
            unique case (st)
                S_CAP: if (in_valid) begin
                    cap_en = 1'b1;
                    if (cnt == LAST_CFG) begin
                        nxt = AFTER_CAP;
                        cnt_clr = 1'b1;
                    end else cnt_inc = 1'b1;
                end
                S_FWD: if (in_valid) begin
                    fwd_en = 1'b1;
                    if (cnt == LAST_FWD) begin
                        nxt = S_PIN;
                        cnt_clr = 1'b1;
                    end else cnt_inc = 1'b1;
                end
                S_PIN: if (in_valid) begin
                    pin_en = 1'b1;
                    if (cnt == LAST_PAY) begin
                        nxt = S_MAC;
                        cnt_clr = 1'b1;
                    end else cnt_inc = 1'b1;
                end
                S_MAC: begin
                    mac_go = 1'b1;
                    nxt    = S_EMIT;
                end
                S_EMIT: begin
                    emit_en = 1'b1;
                    if (cnt == LAST_PAY) begin
                        nxt = S_DONE;
                        cnt_clr = 1'b1;
                    end else cnt_inc = 1'b1;
                end
                S_DONE: nxt = S_DONE;
                default: nxt = S_CAP;
            endcase
        end
    end

    assign cap_full = (st != S_CAP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= fwd_en | emit_en;
            out_bit   <= fwd_en ? in_bit : (emit_en ? pay_msb : 1'b0);
        end
    end
endmodule

// File: rtl/canary_cfg.sv
module canary_cfg #(
    parameter int              CFG_W       = 5,
    parameter logic [CFG_W-1:0] DEFAULT_CFG = 5'h13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             in_bit,
    input  logic             commit,
    input  logic             cap_full,
    output logic [CFG_W-1:0] cap_q,
    output logic [CFG_W-1:0] active_cfg,
    output logic             cfg_err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= '0;
            active_cfg <= DEFAULT_CFG;
            cfg_err    <= 1'b0;
        end else begin
            if (cap_en) cap_q <= {cap_q[CFG_W-2:0], in_bit};
            if (commit) begin
                if (cap_full) begin
                    active_cfg <= cap_q;
                    cfg_err    <= 1'b0;
                end else begin
                    cfg_err    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/canary_mac.sv
module canary_mac #(
    parameter int               PAY_W = 64,
    parameter int               CFG_W = 5,
    parameter logic [PAY_W-1:0] KEY   = 64'hA5C3_0F1E_7B29_D486
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_en,
    input  logic             in_bit,
    input  logic             mac_go,
    input  logic             emit_en,
    input  logic [CFG_W-1:0] active_cfg,
    output logic             pay_msb,
    output logic [PAY_W-1:0] st_q
);
    logic [PAY_W-1:0] sr, mixed, rotated;
    int               amt;

    always_comb begin
        mixed   = sr ^ KEY ^ st_q;
        amt     = (int'(active_cfg) + 1) % PAY_W;
        rotated = (amt == 0) ? mixed : ((mixed << amt) | (mixed >> (PAY_W - amt)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            st_q <= '0;
        end else if (pin_en) begin
            sr <= {sr[PAY_W-2:0], in_bit};
        end else if (mac_go) begin
            sr   <= rotated;
            st_q <= st_q ^ sr ^ KEY;
        end else if (emit_en) begin
            sr <= {sr[PAY_W-2:0], 1'b0};
        end
    end

    assign pay_msb = sr[PAY_W-1];
endmodule

// File: rtl/canary_cell.sv
module canary_cell
    import canary_pkg::*;
#(
    parameter int               CFG_W       = 5,
    parameter int               DOWN_CELLS  = 3,
    parameter int               PAY_W       = 64,
    parameter logic [PAY_W-1:0] KEY         = 64'hA5C3_0F1E_7B29_D486,
    parameter logic [CFG_W-1:0] DEFAULT_CFG = 5'h13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             commit,
    output logic             out_valid,
    output logic             out_bit,
    output logic [CFG_W-1:0] active_cfg,
    output logic             cfg_err
);
    localparam int FWD_BITS = DOWN_CELLS * CFG_W;

    seq_state_t       st;
    logic             cap_en, cap_full, pin_en, mac_go, emit_en, pay_msb;
    logic [CFG_W-1:0] cap_q;
    logic [PAY_W-1:0] st_q;

    canary_seq #(.CFG_W(CFG_W), .FWD_BITS(FWD_BITS), .PAY_W(PAY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .commit(commit), .pay_msb(pay_msb), .st(st), .cap_en(cap_en),
        .cap_full(cap_full), .pin_en(pin_en), .mac_go(mac_go),
        .emit_en(emit_en), .out_valid(out_valid), .out_bit(out_bit)
    );

    canary_cfg #(.CFG_W(CFG_W), .DEFAULT_CFG(DEFAULT_CFG)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .in_bit(in_bit),
        .commit(commit), .cap_full(cap_full), .cap_q(cap_q),
        .active_cfg(active_cfg), .cfg_err(cfg_err)
    );

    canary_mac #(.PAY_W(PAY_W), .CFG_W(CFG_W), .KEY(KEY)) u_mac (
        .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .in_bit(in_bit),
        .mac_go(mac_go), .emit_en(emit_en), .active_cfg(active_cfg),
        .pay_msb(pay_msb), .st_q(st_q)
    );
endmodule

// File: rtl/canary_cell_chk.sv
module canary_cell_chk
    import canary_pkg::*;
#(
    parameter int CFG_W = 5,
    parameter int PAY_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_bit,
    input logic             commit,
    input logic             out_valid,
    input logic             out_bit,
    input logic [CFG_W-1:0] active_cfg,
    input logic             cfg_err,
    input seq_state_t       st,
    input logic [CFG_W-1:0] cap_q,
    input logic             mac_go,
    input logic [PAY_W-1:0] st_q
);
    // R1: a bit accepted during capture never reaches the output
    p_cap_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CAP && in_valid) |=> !out_valid);

    // R2: forwarded bits appear one cycle later, unchanged
    p_fwd_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FWD && in_valid && !commit) |=> (out_valid && out_bit == $past(in_bit)));

    // R4: chained state moves only on the mixing cycle
    p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_go |=> $stable(st_q));

    // R6: a commit after a full capture loads the field and clears the flag
    p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && st != S_CAP) |=> (active_cfg == $past(cap_q) && !cfg_err));

    // R7: a commit during capture keeps the configuration and raises the flag
    p_short_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && st == S_CAP) |=> (cfg_err && $stable(active_cfg)));

    // R7: the flag holds between commits
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_err));

    // R8: the active configuration changes only after a commit
    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_cfg));

    // R9: once the digest has been sent, nothing more is output
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE) |=> !out_valid);
endmodule

bind canary_cell canary_cell_chk #(.CFG_W(CFG_W), .PAY_W(PAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .commit(commit), .out_valid(out_valid), .out_bit(out_bit),
    .active_cfg(active_cfg), .cfg_err(cfg_err), .st(st), .cap_q(cap_q),
    .mac_go(mac_go), .st_q(st_q)
);

// File: tb/canary_cell_bench.sv
module canary_cell_bench;
    localparam int          CFG_W = 5;
    localparam int          DOWN  = 3;
    localparam int          FWD_W = DOWN * CFG_W;
    localparam int          PAY_W = 64;
    localparam logic [63:0] KEY   = 64'hA5C3_0F1E_7B29_D486;
    localparam logic [4:0]  DEF   = 5'h13;
    localparam int          MSG_OUT = FWD_W + PAY_W;

    typedef struct packed {
        logic [4:0]  cfg;
        logic [14:0] fwd;
        logic [63:0] pay;
        logic        gap;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{cfg: 5'h0A, fwd: 15'h5A3C, pay: 64'h0123_4567_89AB_CDEF, gap: 1'b0},
        '{cfg: 5'h1F, fwd: 15'h7FFF, pay: 64'hFFFF_0000_FFFF_0000, gap: 1'b1},
        '{cfg: 5'h00, fwd: 15'h0001, pay: 64'h0000_0000_0000_0000, gap: 1'b0},
        '{cfg: 5'h13, fwd: 15'h2AAA, pay: 64'hDEAD_BEEF_CAFE_F00D, gap: 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic commit = 1'b0;
    logic out_valid, out_bit, cfg_err;
    logic [4:0] active_cfg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ocnt = 0;
    logic [MSG_OUT-1:0] obuf = '0;
    logic [63:0] exp_state = '0;
    logic [4:0]  exp_cfg = DEF;

    always #4 clk = ~clk;

    canary_cell u_canary_cell (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .commit(commit), .out_valid(out_valid), .out_bit(out_bit),
        .active_cfg(active_cfg), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            obuf <= {obuf[MSG_OUT-2:0], out_bit};
            ocnt <= ocnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] digest(logic [63:0] p, logic [63:0] s, logic [4:0] a);
        logic [63:0] m;
        int r;
        m = p ^ KEY ^ s;
        r = (int'(a) + 1) % 64;
        return (r == 0) ? m : ((m << r) | (m >> (64 - r)));
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [83:0] bits, input int n, input logic gap);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = bits[i];
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic full_session(input vec_t v, input string tag);
        int base;
        base = ocnt;
        send_bits({v.cfg, v.fwd, v.pay}, 84, v.gap);
        wait_cycles(80);
        check(ocnt - base == MSG_OUT, {tag, " R1 output length"}, 64'(ocnt - base), 64'(MSG_OUT));
        check(obuf[MSG_OUT-1:PAY_W] == v.fwd, {tag, " R2 forwarded fields"},
              64'(obuf[MSG_OUT-1:PAY_W]), 64'(v.fwd));
        check(obuf[PAY_W-1:0] == digest(v.pay, exp_state, exp_cfg), {tag, " R3 digest"},
              obuf[PAY_W-1:0], digest(v.pay, exp_state, exp_cfg));
        check(active_cfg == exp_cfg, {tag, " R8 cfg before commit"}, 64'(active_cfg), 64'(exp_cfg));
        exp_state = exp_state ^ v.pay ^ KEY;
    endtask

    initial begin
        vec_t t;
        int base;
        wait_cycles(3);
        check(active_cfg == DEF, "R5 reset cfg", 64'(active_cfg), 64'(DEF));
        check(cfg_err == 1'b0, "R5 reset err", 64'(cfg_err), 64'd0);
        check(out_valid == 1'b0, "R5 reset out_valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cycles(2);

        // Table walk: R1 R2 R3 R4 (chained state) R6 R11 (gapped entries)
        for (int k = 0; k < 4; k++) begin
            full_session(VECS[k], "table");
            do_commit();
            check(active_cfg == VECS[k].cfg, "R6 commit loads cfg", 64'(active_cfg), 64'(VECS[k].cfg));
            check(cfg_err == 1'b0, "R6 err clear", 64'(cfg_err), 64'd0);
            exp_cfg = VECS[k].cfg;
        end

        // R9: bits after the digest are ignored
        t = '{cfg: 5'h07, fwd: 15'h1234, pay: 64'h1111_2222_3333_4444, gap: 1'b0};
        full_session(t, "R9 pre");
        base = ocnt;
        send_bits(84'h3FF_FFFF, 26, 1'b0);
        wait_cycles(4);
        check(ocnt == base, "R9 no output after digest", 64'(ocnt), 64'(base));
        do_commit();
        exp_cfg = 5'h07;
        t = '{cfg: 5'h02, fwd: 15'h4321, pay: 64'h0F0F_0F0F_F0F0_F0F0, gap: 1'b0};
        full_session(t, "R9 state untouched");
        do_commit();
        exp_cfg = 5'h02;

        // R7: short capture keeps configuration and raises the flag
        base = ocnt;
        send_bits(84'h5, 3, 1'b0);
        do_commit();
        check(active_cfg == exp_cfg, "R7 cfg kept", 64'(active_cfg), 64'(exp_cfg));
        check(cfg_err == 1'b1, "R7 err set", 64'(cfg_err), 64'd1);
        check(ocnt == base, "R1 short capture not forwarded", 64'(ocnt), 64'(base));
        wait_cycles(10);
        check(cfg_err == 1'b1, "R7 err held", 64'(cfg_err), 64'd1);

        // R10: abort inside the payload, then a clean session
        send_bits({5'h19, 15'h0F0F, 30'h2AAA_5555}, 50, 1'b0);
        do_commit();
        check(active_cfg == 5'h19, "R10 cfg from aborted message", 64'(active_cfg), 64'h19);
        check(cfg_err == 1'b0, "R6 err cleared by full capture", 64'(cfg_err), 64'd0);
        exp_cfg = 5'h19;
        t = '{cfg: 5'h1E, fwd: 15'h00FF, pay: 64'h8000_0000_0000_0001, gap: 1'b1};
        full_session(t, "R10 state unchanged by abort");
        do_commit();
        check(active_cfg == 5'h1E, "R6 final commit", 64'(active_cfg), 64'h1E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule